// File: doc/BRIEF.md
# Transmit Clock Loss Monitor

This block watches a transmit-side clock from a continuous, jitter-free reference clock domain and reports when that clock has stopped. The reference clock drives a strobe counter that marks windows of `WINDOW` reference cycles. Within each window the block looks for at least one rising edge of the monitored clock. At the strobe that closes the window it updates the loss flag. While the flag is set, a registered driver enable goes low so that the line drivers can be placed in high impedance and no data is sent.

The clock to monitor follows the path configuration. When the smoothing stage sits in the transmit path, the block watches the smoothed clock. Otherwise it watches the remote-loopback recovered clock when remote loopback is active, and the plain transmit input clock in all other cases. The selected clock passes through a two-flop synchronizer and a rising-edge detector in the reference domain.

Top module: `clkmon_top`

## Requirements
- R1: A window strobe occurs once every `WINDOW` (default 10) reference cycles, counted from reset release. `clkLost` and `drvEnable` change only at the clock edge that ends a window.
- R2: If the monitored clock showed at least one rising edge (as seen after the synchronizer) during a window, `clkLost` is 0 after that window's strobe.
- R3: If no rising edge of the monitored clock was seen during a window, `clkLost` is 1 after that window's strobe.
- R4: `drvEnable` is 1 exactly when `clkLost` is 0. Both are updated at the same strobe edge.
- R5: When `jaMode` is 2'b01 (smoothing stage in the transmit path), only `smoothClk` is monitored. This holds whatever the value of `loopMode`.
- R6: When `jaMode` is not 2'b01 and `loopMode` is 2'b10 (remote loopback), only `loopClk` is monitored, and activity on `txClk` has no effect.
- R7: In every other combination (`jaMode` 00, 10 or 11, with `loopMode` 00, 01 or 11), only `txClk` is monitored.
- R8: While `rstN` is low at a rising reference edge, `clkLost` becomes 1 and `drvEnable` becomes 0. Both keep these values until the first strobe after reset release.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Continuous reference clock |
| rstN | input | 1 | Synchronous reset, active low |
| txClk | input | 1 | Transmit input clock |
| smoothClk | input | 1 | Smoothed clock from the jitter-smoothing stage |
| loopClk | input | 1 | Recovered clock used during remote loopback |
| jaMode | input | 2 | Smoothing-stage placement; 2'b01 puts it in the transmit path |
| loopMode | input | 2 | Loopback selection; 2'b10 is remote loopback |
| clkLost | output | 1 | Loss-of-clock flag, updated at each strobe |
| drvEnable | output | 1 | Line driver enable; 0 places the drivers in high impedance |

## Verification
The hardest case to reach from the ports is a clock whose period is longer than one window. With such a clock, some windows contain a rising edge and their neighbours do not, so the flag must alternate. The bench produces this with a clock whose half period is eight reference cycles. Every candidate clock is generated on the falling reference edge from a per-clock divider, so the synchronizer delay is deterministic. Mode switches are made with a running clock on a source that is not selected and a stopped clock on the source that is selected, to show that the ignored source never clears the flag.

// File: rtl/clkmon_pkg.sv
package clkmon_pkg;

  localparam logic [1:0] JaTxPath   = 2'b01;
  localparam logic [1:0] LoopRemote = 2'b10;

  typedef struct packed {
    logic windowEnd;
  } ctrlStrobes_t;

  typedef enum logic [1:0] {
    SrcTx     = 2'd0,
    SrcSmooth = 2'd1,
    SrcLoop   = 2'd2
  } clkSrc_t;

endpackage

// File: rtl/clkmon_ctrl.sv
module clkmon_ctrl
  import clkmon_pkg::*;
#(
  parameter int WINDOW = 10
) (
  input  logic         clk,
  input  logic         rstN,
  output ctrlStrobes_t strobes
);

  localparam int CntW = (WINDOW > 1) ? $clog2(WINDOW) : 1;
  localparam logic [CntW-1:0] LastCnt = CntW'(WINDOW - 1);

  logic [CntW-1:0] winCnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      winCnt <= '0;
    end else if (winCnt == LastCnt) begin
      winCnt <= '0;
    end else begin
      winCnt <= winCnt + 1'b1;
    end
  end

  always_comb begin
    strobes.windowEnd = (winCnt == LastCnt);
  end

endmodule

// File: rtl/clkmon_dp.sv
module clkmon_dp
  import clkmon_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         txClk,
  input  logic         smoothClk,
  input  logic         loopClk,
  input  logic [1:0]   jaMode,
  input  logic [1:0]   loopMode,
  input  ctrlStrobes_t strobes,
  output logic         clkLost,
  output logic         drvEnable
);

  clkSrc_t                src;
  logic                   selClk;
  logic [SYNC_STAGES-1:0] syncChain;
  logic                   prevLvl;
  logic                   riseSeen;
  logic                   seenInWin;
  logic                   winActive;

  always_comb begin
    if (jaMode == JaTxPath) begin
      src = SrcSmooth;
    end else if (loopMode == LoopRemote) begin
      src = SrcLoop;
    end else begin
      src = SrcTx;
    end
    unique case (src)
      SrcSmooth: selClk = smoothClk;
      SrcLoop:   selClk = loopClk;
      default:   selClk = txClk;
    endcase
  end

  genvar gi;
  generate
    for (gi = 0; gi < SYNC_STAGES; gi++) begin : g_sync
      if (gi == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (!rstN) syncChain[gi] <= 1'b0;
          else       syncChain[gi] <= selClk;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (!rstN) syncChain[gi] <= 1'b0;
          else       syncChain[gi] <= syncChain[gi-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) prevLvl <= 1'b0;
    else       prevLvl <= syncChain[SYNC_STAGES-1];
  end

  assign riseSeen  = syncChain[SYNC_STAGES-1] & ~prevLvl;
  assign winActive = seenInWin | riseSeen;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      seenInWin <= 1'b0;
      clkLost   <= 1'b1;
      drvEnable <= 1'b0;
    end else if (strobes.windowEnd) begin
      seenInWin <= 1'b0;
      clkLost   <= ~winActive;
      drvEnable <= winActive;
    end else if (riseSeen) begin
      seenInWin <= 1'b1;
    end
  end

endmodule

// File: rtl/clkmon_top.sv
module clkmon_top
  import clkmon_pkg::*;
#(
  parameter int WINDOW      = 10,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       txClk,
  input  logic       smoothClk,
  input  logic       loopClk,
  input  logic [1:0] jaMode,
  input  logic [1:0] loopMode,
  output logic       clkLost,
  output logic       drvEnable
);

  ctrlStrobes_t strobes;

  clkmon_ctrl #(.WINDOW(WINDOW)) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes)
  );

  clkmon_dp #(.SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .txClk     (txClk),
    .smoothClk (smoothClk),
    .loopClk   (loopClk),
    .jaMode    (jaMode),
    .loopMode  (loopMode),
    .strobes   (strobes),
    .clkLost   (clkLost),
    .drvEnable (drvEnable)
  );

endmodule

// File: rtl/clkmon_chk.sv
module clkmon_chk #(
  parameter int WINDOW      = 10,
  parameter int SYNC_STAGES = 2
) (
  input logic       clk,
  input logic       rstN,
  input logic       txClk,
  input logic       smoothClk,
  input logic       loopClk,
  input logic [1:0] jaMode,
  input logic [1:0] loopMode,
  input logic       clkLost,
  input logic       drvEnable
);

  localparam int QuietLimit = 2 * WINDOW + SYNC_STAGES + 2;
  localparam int PhW = (WINDOW > 1) ? $clog2(WINDOW) : 1;
  localparam int IdW = $clog2(QuietLimit + 2);

  logic [PhW-1:0] phase;
  logic [IdW-1:0] idleCnt;
  logic [6:0]     lastIn;

  always_ff @(posedge clk) begin
    if (!rstN) phase <= '0;
    else if (phase == PhW'(WINDOW - 1)) phase <= '0;
    else phase <= phase + 1'b1;
  end

  always_ff @(posedge clk) begin
    lastIn <= {txClk, smoothClk, loopClk, jaMode, loopMode};
    if (!rstN) begin
      idleCnt <= '0;
    end else if ({txClk, smoothClk, loopClk, jaMode, loopMode} != lastIn) begin
      idleCnt <= '0;
    end else if (idleCnt < IdW'(QuietLimit)) begin
      idleCnt <= idleCnt + 1'b1;
    end
  end

  // R8
  a_r8_reset_sets_lost: assert property (@(posedge clk)
    !rstN |=> (clkLost && !drvEnable));

  // R1
  a_r1_change_only_at_strobe: assert property (@(posedge clk) disable iff (!rstN)
    (phase != '0) |-> ($stable(clkLost) && $stable(drvEnable)));

  // R4
  a_r4_enable_tracks_flag: assert property (@(posedge clk) disable iff (!rstN)
    (drvEnable != clkLost));

  // R2
  a_r2_clear_needs_activity: assert property (@(posedge clk) disable iff (!rstN)
    $fell(clkLost) |-> (idleCnt < IdW'(QuietLimit)));

  // R3
  a_r3_idle_sets_lost: assert property (@(posedge clk) disable iff (!rstN)
    (idleCnt == IdW'(QuietLimit)) |-> clkLost);

endmodule

bind clkmon_top clkmon_chk #(.WINDOW(WINDOW), .SYNC_STAGES(SYNC_STAGES)) i_clkmon_chk (
  .clk       (clk),
  .rstN      (rstN),
  .txClk     (txClk),
  .smoothClk (smoothClk),
  .loopClk   (loopClk),
  .jaMode    (jaMode),
  .loopMode  (loopMode),
  .clkLost   (clkLost),
  .drvEnable (drvEnable)
);

// File: tb/test_clkmon_top.sv
`timescale 1ns/1ps
module test_clkmon_top;

  localparam int W = 10;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       txClk = 1'b0;
  logic       smoothClk = 1'b0;
  logic       loopClk = 1'b0;
  logic [1:0] jaMode = 2'b00;
  logic [1:0] loopMode = 2'b00;
  logic       clkLost;
  logic       drvEnable;

  int errors = 0;
  int checks = 0;
  int cycles = 0;
  bit done = 0;
  string curReq = "R8";

  int halfTx = 0, halfSm = 0, halfLp = 0;
  int cntTx = 0, cntSm = 0, cntLp = 0;

  // reference model state
  bit hist[$];
  int nPos = 0;
  bit anyRise = 0;
  bit expLost = 1;
  bit expDrv = 0;

  always #4 clk = ~clk;

  clkmon_top #(.WINDOW(W)) i_clkmon_top (
    .clk(clk), .rstN(rstN), .txClk(txClk), .smoothClk(smoothClk),
    .loopClk(loopClk), .jaMode(jaMode), .loopMode(loopMode),
    .clkLost(clkLost), .drvEnable(drvEnable)
  );

  function automatic bit pickClk();
    if (jaMode == 2'b01) return smoothClk;
    if (loopMode == 2'b10) return loopClk;
    return txClk;
  endfunction

  initial begin
    hist = '{1'b0, 1'b0, 1'b0};
  end

  always @(posedge clk) begin
    if (!rstN) begin
      hist = '{1'b0, 1'b0, 1'b0};
      nPos = 0; anyRise = 0; expLost = 1; expDrv = 0;
    end else begin
      nPos++;
      if (hist[1] && !hist[2]) anyRise = 1;
      if (nPos % W == 0) begin
        expLost = !anyRise;
        expDrv  = anyRise;
        anyRise = 0;
      end
      hist.push_front(pickClk());
      void'(hist.pop_back());
    end
  end

  always @(negedge clk) begin
    cycles++;
    if (cycles > 2) begin
      checks++;
      if (clkLost !== expLost) begin
        errors++;
        $display("FAIL %s clkLost act=%0b exp=%0b cycle=%0d", curReq, clkLost, expLost, cycles);
      end
      checks++;
      if (drvEnable !== expDrv) begin
        errors++;
        $display("FAIL %s/R4 drvEnable act=%0b exp=%0b cycle=%0d", curReq, drvEnable, expDrv, cycles);
      end
    end
    if (halfTx > 0) begin cntTx++; if (cntTx >= halfTx) begin txClk = ~txClk; cntTx = 0; end end
    if (halfSm > 0) begin cntSm++; if (cntSm >= halfSm) begin smoothClk = ~smoothClk; cntSm = 0; end end
    if (halfLp > 0) begin cntLp++; if (cntLp >= halfLp) begin loopClk = ~loopClk; cntLp = 0; end end
    if (cycles > 200000 && !done) begin
      done = 1;
      errors++;
      checks++;
      $display("FAIL watchdog expired act=running exp=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic phase(input string req, input logic [1:0] ja, input logic [1:0] lp,
                       input int hTx, input int hSm, input int hLp, input int n);
    @(negedge clk);
    curReq = req;
    jaMode = ja; loopMode = lp;
    halfTx = hTx; halfSm = hSm; halfLp = hLp;
    repeat (n) @(negedge clk);
  endtask

  initial begin
    halfTx = 2;
    repeat (3) @(negedge clk);
    // R8: flag set in reset even with a running clock
    checks++;
    if (clkLost !== 1'b1 || drvEnable !== 1'b0) begin
      errors++;
      $display("FAIL R8 reset act=%0b%0b exp=10", clkLost, drvEnable);
    end
    rstN = 1'b1;
    repeat (W - 2) @(negedge clk);   // R8: still set before first strobe
    phase("R7", 2'b00, 2'b00, 2, 0, 0, 60);
    phase("R3", 2'b00, 2'b00, 0, 3, 1, 60);
    phase("R2", 2'b00, 2'b00, 1, 0, 0, 60);
    phase("R6", 2'b10, 2'b10, 0, 0, 1, 60);
    phase("R6", 2'b00, 2'b10, 2, 2, 0, 60);
    phase("R5", 2'b01, 2'b10, 0, 3, 0, 60);
    phase("R5", 2'b01, 2'b00, 1, 0, 1, 60);
    phase("R7", 2'b11, 2'b11, 3, 0, 0, 60);
    phase("R7", 2'b10, 2'b01, 0, 1, 1, 60);
    phase("R1", 2'b00, 2'b00, 8, 0, 0, 120);
    phase("R1", 2'b00, 2'b00, 5, 0, 0, 80);
    phase("R8", 2'b00, 2'b00, 2, 0, 0, 5);
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    repeat (40) @(negedge clk);
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule